// File: doc/BRIEF.md
# Predicate-Count Vector Incrementer

This block takes one wide vector operand and a lane mask. The mask holds one bit per vector byte. The block finds how many lanes are active at a chosen lane width and adds that number to every lane of the vector. A 2-bit width code picks the lane width: 16, 32 or 64 bits. The result is meant to be written back over the operand it was computed from. The caller feeds the old register value in and stores the returned value in the same register.

Work is started by a one-cycle strobe. The sum is registered and comes out on the next clock edge, together with a one-cycle valid pulse. Width code 00 is not a legal encoding. For that code the block raises an undefined-encoding flag and returns the operand unmodified. The vector width is a parameter.

Top module: `pred_inc_vec`

## Requirements
- R1: When `start_i` is high with `size_i` = 2'b00, the next cycle shows `undef_o` = 1, `valid_o` = 1 and `res_o` equal to the `vec_i` that was presented.
- R2: Width code 2'b01 selects 16-bit lanes, 2'b10 selects 32-bit lanes and 2'b11 selects 64-bit lanes. Lane e occupies bits [e*W +: W] of the vector, where W is the lane width.
- R3: Lane e counts as active only when mask bit e*(W/8) is set. Every other mask bit inside that lane's group has no effect on the result.
- R4: The active-lane count is added to every lane. It ranges from 0 (no active lanes) up to VLEN/W (all lanes active). An all-zero mask leaves every lane unchanged.
- R5: Each lane sum wraps modulo 2^W. A carry never reaches the neighbouring lane.
- R6: After a start with a legal width code, the result appears on `res_o` one clock later. In that cycle `valid_o` pulses high for exactly one cycle and `undef_o` is low.
- R7: In any cycle after which `start_i` was low, `res_o` keeps its previous value and `valid_o` and `undef_o` stay low.
- R8: While `rst_n` is low, `res_o`, `valid_o` and `undef_o` are all zero.
- R9: VLEN must be a power of two from 128 to 2048. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request strobe |
| size_i | input | 2 | Lane width code (00 illegal, 01/10/11 = 16/32/64 bits) |
| vec_i | input | VLEN | Operand vector |
| pred_i | input | VLEN/8 | Lane mask, one bit per byte |
| res_o | output | VLEN | Registered result vector |
| valid_o | output | 1 | Result strobe, one cycle |
| undef_o | output | 1 | Illegal width code flag, aligned with `valid_o` |

## Verification
The checker watches several rules on every cycle. It checks the one-cycle latency and the single-cycle valid pulse. It checks that the result holds between requests. It checks that the illegal code passes the operand through with the flag raised, and that an empty mask returns the operand unchanged.

Some behaviour can only be shown by the bench's scoreboard, because it depends on the lane width and the mask contents together. This covers the actual count at each width, the choice of which mask bit stands for each lane, and wrap-around within a lane. The scoreboard compares against a reference model for random operands and masks. It also runs all-active masks, masks where only the ignored bits are set, and lanes forced to overflow.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

  // Lane width selector; the numeric value feeds the shift 8 << code.
  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_DBL  = 2'b11
  } lane_sz_e;

  localparam int unsigned MIN_VLEN = 128;
  localparam int unsigned MAX_VLEN = 2048;

  function automatic bit vlen_ok(input int unsigned v);
    return (v >= MIN_VLEN) && (v <= MAX_VLEN) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/pinc_pop_count.sv
// Counts mask bits sampled at a fixed stride (one sample per lane).
module pinc_pop_count #(
  parameter int unsigned P_BITS = 32,
  parameter int unsigned STRIDE = 2,
  parameter int unsigned CW     = 5
) (
  input  logic [P_BITS-1:0] pred,
  output logic [CW-1:0]     cnt
);
  localparam int unsigned LANES = P_BITS / STRIDE;

  always_comb begin
    cnt = '0;
    for (int e = 0; e < LANES; e++) begin
      cnt = cnt + CW'(pred[e*STRIDE]);
    end
  end

endmodule

// File: rtl/pinc_lane_add.sv
// Adds one count to every lane of width EW; each lane wraps on its own.
module pinc_lane_add #(
  parameter int unsigned VLEN = 256,
  parameter int unsigned EW   = 16,
  parameter int unsigned CW   = 5
) (
  input  logic [VLEN-1:0] vec,
  input  logic [CW-1:0]   cnt,
  output logic [VLEN-1:0] sum
);
  localparam int unsigned LANES = VLEN / EW;

  logic [EW-1:0] inc;
  assign inc = EW'(cnt);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sum[g*EW +: EW] = vec[g*EW +: EW] + inc;
  end

endmodule

// File: rtl/pred_inc_vec.sv
module pred_inc_vec
  import pinc_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  output logic [VLEN-1:0]   res_o,
  output logic              valid_o,
  output logic              undef_o
);
  localparam int unsigned PLEN    = VLEN / 8;
  localparam int unsigned MAX_CNT = VLEN / 16;
  localparam int unsigned CW      = $clog2(MAX_CNT + 1);

  // R9: reject unsupported vector widths at elaboration.
  if (!vlen_ok(VLEN)) begin : g_bad_vlen
    $error("pred_inc_vec: VLEN must be a power of two in [128,2048]");
  end

  logic [VLEN-1:0] sum_by_sz [1:3];

  // One counter and one adder bank per legal lane width.
  for (genvar s = 1; s < 4; s++) begin : g_width
    logic [CW-1:0] cnt;

    pinc_pop_count #(
      .P_BITS (PLEN),
      .STRIDE (1 << s),
      .CW     (CW)
    ) u_cnt (
      .pred (pred_i),
      .cnt  (cnt)
    );

    pinc_lane_add #(
      .VLEN (VLEN),
      .EW   (8 << s),
      .CW   (CW)
    ) u_add (
      .vec (vec_i),
      .cnt (cnt),
      .sum (sum_by_sz[s])
    );
  end

  logic [VLEN-1:0] res_d, res_q;
  logic            valid_d, valid_q;
  logic            undef_d, undef_q;
  logic            res_en;

  assign res_en = start_i;

  always_comb begin
    res_d   = res_q;
    valid_d = 1'b0;
    undef_d = 1'b0;
    if (start_i) begin
      valid_d = 1'b1;
      unique case (lane_sz_e'(size_i))
        SZ_HALF: res_d = sum_by_sz[1];
        SZ_WORD: res_d = sum_by_sz[2];
        SZ_DBL:  res_d = sum_by_sz[3];
        default: begin
          res_d   = vec_i;
          undef_d = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      valid_q <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      undef_q <= undef_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign res_o   = res_q;
  assign valid_o = valid_q;
  assign undef_o = undef_q;

endmodule

// File: rtl/pinc_chk.sv
module pinc_chk #(
  parameter int unsigned VLEN = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        size_i,
  input logic [VLEN-1:0]   vec_i,
  input logic [VLEN/8-1:0] pred_i,
  input logic [VLEN-1:0]   res_o,
  input logic              valid_o,
  input logic              undef_o
);

  a_r1_rsvd_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && size_i == 2'b00) |=> (undef_o && valid_o && res_o == $past(vec_i)));

  a_r4_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && size_i != 2'b00 && pred_i == '0) |=> (res_o == $past(vec_i)));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && size_i != 2'b00) |=> (valid_o && !undef_o));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(res_o) && !valid_o && !undef_o));

  a_r1_flag_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> valid_o);

endmodule

bind pred_inc_vec pinc_chk #(.VLEN(VLEN)) u_pinc_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .size_i  (size_i),
  .vec_i   (vec_i),
  .pred_i  (pred_i),
  .res_o   (res_o),
  .valid_o (valid_o),
  .undef_o (undef_o)
);

// File: tb/test_pred_inc_vec.sv
module test_pred_inc_vec;
  localparam int VL = 256;
  localparam int PL = VL / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    size_i = 2'b00;
  logic [VL-1:0] vec_i = '0;
  logic [PL-1:0] pred_i = '0;
  logic [VL-1:0] res_o;
  logic          valid_o;
  logic          undef_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [VL-1:0] res;
    logic          und;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  logic [VL-1:0] last_res = '0;

  pred_inc_vec #(.VLEN(VL)) i_pred_inc_vec (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .size_i (size_i),
    .vec_i (vec_i), .pred_i (pred_i), .res_o (res_o), .valid_o (valid_o),
    .undef_o (undef_o)
  );

  always #4 clk = ~clk;

  function automatic logic [VL-1:0] model(input logic [1:0] sz,
                                          input logic [VL-1:0] v,
                                          input logic [PL-1:0] p);
    int w, n, cnt;
    logic [VL-1:0] r;
    logic [63:0] lane, msk;
    if (sz == 2'b00) return v;
    w   = 8 << sz;
    n   = VL / w;
    cnt = 0;
    r   = '0;
    msk = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int e = 0; e < n; e++) if (p[e*(w/8)]) cnt++;
    for (int e = 0; e < n; e++) begin
      lane = 64'(v >> (e*w)) & msk;
      lane = (lane + 64'(cnt)) & msk;
      r    = r | (VL'(lane) << (e*w));
    end
    return r;
  endfunction

  function automatic logic [VL-1:0] rnd_vec();
    logic [VL-1:0] r;
    for (int i = 0; i < VL/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [VL-1:0] act, input logic [VL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic [VL-1:0] v,
                       input logic [PL-1:0] p, input string tag);
    exp_t x;
    @(negedge clk);
    start_i = 1'b1;
    size_i  = sz;
    vec_i   = v;
    pred_i  = p;
    x.res = model(sz, v, p);
    x.und = (sz == 2'b00);
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      vec_i   = rnd_vec();
      pred_i  = PL'($urandom);
      size_i  = 2'($urandom);
    end
  endtask

  // Monitor: pops the scoreboard whenever a result strobe appears.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (sb.size() == 0) begin
          check(1'b0, "R6 unexpected valid", {VL{1'b0}}, {VL{1'b0}});
        end else begin
          exp_t x;
          x = sb.pop_front();
          check(res_o == x.res, x.tag, res_o, x.res);
          check(undef_o == x.und, {x.tag, " flag"}, VL'(undef_o), VL'(x.und));
          last_res = x.res;
        end
      end else if (undef_o) begin
        check(1'b0, "R7 flag without valid", VL'(undef_o), '0);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VL-1:0] v;
    repeat (3) @(negedge clk);
    // R8: outputs cleared during reset
    check(res_o == '0 && !valid_o && !undef_o, "R8 reset state", res_o, '0);
    // R9: the bench width is a legal power of two in range
    check(VL >= 128 && VL <= 2048 && (VL & (VL - 1)) == 0, "R9 legal VLEN",
          VL'(VL), VL'(VL));
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R1: reserved code passes the operand through and flags it
    issue(2'b00, rnd_vec(), '1, "R1 reserved code");
    issue(2'b00, rnd_vec(), PL'($urandom), "R1 reserved code b2b");
    idle(2);

    for (int s = 1; s < 4; s++) begin
      // R4: empty mask adds zero
      issue(2'(s), rnd_vec(), '0, "R4 empty mask");
      // R4: all-active mask adds lane count
      issue(2'(s), rnd_vec(), '1, "R4 full mask");
      // R3: only non-sampled bits set -> count zero
      begin
        logic [PL-1:0] p = '1;
        for (int e = 0; e < PL; e += (1 << s)) p[e] = 1'b0;
        issue(2'(s), rnd_vec(), p, "R3 ignored mask bits");
      end
      // R5: every lane at its maximum wraps
      issue(2'(s), '1, '1, "R5 lane wrap");
      // R2: random operands at this width
      for (int k = 0; k < 20; k++) issue(2'(s), rnd_vec(), PL'($urandom), "R2 random");
      idle(1);
    end

    // R6: back-to-back requests across widths
    for (int k = 0; k < 30; k++) issue(2'($urandom), rnd_vec(), PL'($urandom), "R6 stream");
    idle(1);

    // R7: result holds through idle cycles
    idle(3);
    v = last_res;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(res_o == v && !valid_o, "R7 hold", res_o, v);
    end

    idle(2);
    check(sb.size() == 0, "R6 scoreboard drained", VL'(sb.size()), '0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule